// File: doc/BRIEF.md
# Iterative Leading-One Position Unit

This unit takes a single data word and reports where its highest set bit sits, counting from the most significant end: the top bit of the word is position 0 and the bottom bit is position WIDTH-1. A word with no bit set yields the value -1, which appears as all ones on the result port. The unit behaves like a one-source, one-destination arithmetic operation. A caller pulses `start` with the operand, then waits for a one-cycle `done` pulse that carries the result.

The search runs as a shift-and-test loop. An all-zero operand is detected first and answered at once. Any other operand is loaded into a shift register. On each following cycle the unit examines the register's top bit. When that bit is clear, the register moves left by one place and a position counter goes up by one. Latency therefore depends on the data. Each operation also reports how many cycles it took, so that the average cost over a workload can be measured.

Top module: `msb_locator`

## Requirements
- R1: After reset, `busy`, `done`, `result` and `cycles` are all 0.
- R2: When `start` is accepted with an all-zero operand, `done` rises on the next cycle with `result` all ones (-1), `cycles` equal to 1, and `busy` staying low.
- R3: For a non-zero operand, `result` is the position of the highest set bit counted from the MSB. Bit WIDTH-1 maps to 0 and bit 0 maps to WIDTH-1, so an operand of 1 gives 31 at the default width. The top bit of the 6-bit result is 0.
- R4: For a non-zero operand whose answer is position p, `done` rises p+2 cycles after the cycle in which `start` was accepted.
- R5: `busy` is high from the cycle after a non-zero operand is accepted, and stays high up to the cycle in which `done` rises, where it is low. `done` is never high while `busy` is high.
- R6: `done` is high for exactly one cycle per operation.
- R7: A `start` pulse while `busy` is high is ignored. The running operation finishes with its own result and latency, and no extra `done` follows.
- R8: `cycles` reports the latency of the last operation (1 for zero, p+2 otherwise). `result` and `cycles` hold their values between `done` pulses.
- R9: `start` is accepted in the same cycle that `done` is high, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation with `operand` (taken only when not busy) |
| operand | input | WIDTH (32) | Word to search |
| busy | output | 1 | Search loop running |
| done | output | 1 | One-cycle pulse: `result` and `cycles` are fresh |
| result | output | $clog2(WIDTH)+1 (6) | Leading-one position from the MSB, all ones for a zero operand |
| cycles | output | $clog2(WIDTH+2) (6) | Latency of the last completed operation |

## Verification
The bench uses one reference model for two checks. The position from the model is checked against `result`. The position plus two is checked against the measured `done` latency and against `cycles`. A shift register or position counter that slips by a single step therefore shows at the next `done` as a result that is off by one, together with a latency that is off by one. A controller that reloads on a stray `start` shows in the same way, as a result from the wrong operand or as a second `done`. Zero operands and single-bit operands at both ends of the word are driven directly. Random operands are shifted by random amounts so that every position is reached.

// File: rtl/msb_loc_pkg.sv
package msb_loc_pkg;

  typedef enum logic [0:0] {
    ST_IDLE   = 1'b0,
    ST_SEARCH = 1'b1
  } loc_state_e;

endpackage

// File: rtl/msb_loc_ctrl.sv
module msb_loc_ctrl
  import msb_loc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic op_is_zero,
  input  logic top_bit,
  output logic busy,
  output logic accept,
  output logic accept_zero,
  output logic accept_load,
  output logic finish_found,
  output logic advance,
  output logic done
);

  loc_state_e state_q;

  // named events for the datapath and the assertions
  assign busy         = (state_q == ST_SEARCH);
  assign accept       = start && (state_q == ST_IDLE);
  assign accept_zero  = accept && op_is_zero;
  assign accept_load  = accept && !op_is_zero;
  assign finish_found = busy && top_bit;
  assign advance      = busy && !top_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      done <= accept_zero || finish_found;
      case (state_q)
        ST_IDLE:   if (accept_load)  state_q <= ST_SEARCH;
        ST_SEARCH: if (finish_found) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  // R6: a done is followed by a low cycle unless a new start was taken in it
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  // R5: done and busy never overlap
  assert_busy_excludes_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  // R7: a start during busy does not restart or end the loop early
  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !top_bit) |=> busy);

endmodule

// File: rtl/msb_loc_shifter.sv
module msb_loc_shifter #(
  parameter int WIDTH = 32,
  localparam int POS_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             advance,
  input  logic [WIDTH-1:0] operand,
  output logic             top_bit,
  output logic [POS_W-1:0] pos
);

  logic [WIDTH-1:0] sreg_q;

  function automatic logic [WIDTH-1:0] shift_once(input logic [WIDTH-1:0] v);
    return {v[WIDTH-2:0], 1'b0};
  endfunction

  function automatic logic [POS_W-1:0] step_pos(input logic [POS_W-1:0] p);
    return p + POS_W'(1);
  endfunction

  assign top_bit = sreg_q[WIDTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      pos    <= '0;
    end else if (load) begin
      sreg_q <= operand;
      pos    <= '0;
    end else if (advance) begin
      sreg_q <= shift_once(sreg_q);
      pos    <= step_pos(pos);
    end
  end

  // R3: a load starts the count at position zero
  assert_load_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (pos == '0));

  // R3: each shift step moves the count by exactly one
  assert_step_counts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> (pos == $past(pos) + POS_W'(1)));

  // R3: a loaded non-zero word never shifts out before its top bit is seen
  assert_no_overrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> (sreg_q != '0));

endmodule

// File: rtl/msb_loc_cycles.sv
module msb_loc_cycles #(
  parameter int CYC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_zero,
  input  logic             accept_load,
  input  logic             searching,
  input  logic             finish_found,
  output logic [CYC_W-1:0] last_cycles
);

  logic [CYC_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= '0;
      last_cycles <= '0;
    end else begin
      if (accept_load)    run_q <= CYC_W'(1);
      else if (searching) run_q <= run_q + CYC_W'(1);

      if (accept_zero)       last_cycles <= CYC_W'(1);
      else if (finish_found) last_cycles <= run_q + CYC_W'(1);
    end
  end

  // R8: the running count is at least one while searching
  assert_run_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    searching |-> (run_q != '0));

endmodule

// File: rtl/msb_locator.sv
module msb_locator #(
  parameter int WIDTH = 32,
  localparam int POS_W = $clog2(WIDTH),
  localparam int RES_W = POS_W + 1,
  localparam int CYC_W = $clog2(WIDTH + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] operand,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result,
  output logic [CYC_W-1:0] cycles
);

  logic op_is_zero, top_bit, accept, accept_zero, accept_load;
  logic finish_found, advance;
  logic [POS_W-1:0] pos;

  function automatic logic [RES_W-1:0] none_code();
    return '1;
  endfunction

  function automatic logic [RES_W-1:0] found_code(input logic [POS_W-1:0] p);
    return {1'b0, p};
  endfunction

  assign op_is_zero = (operand == '0);

  msb_loc_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .op_is_zero   (op_is_zero),
    .top_bit      (top_bit),
    .busy         (busy),
    .accept       (accept),
    .accept_zero  (accept_zero),
    .accept_load  (accept_load),
    .finish_found (finish_found),
    .advance      (advance),
    .done         (done)
  );

  msb_loc_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept_load),
    .advance (advance),
    .operand (operand),
    .top_bit (top_bit),
    .pos     (pos)
  );

  msb_loc_cycles #(.CYC_W(CYC_W)) u_cycles (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept_zero  (accept_zero),
    .accept_load  (accept_load),
    .searching    (busy),
    .finish_found (finish_found),
    .last_cycles  (cycles)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            result <= '0;
    else if (accept_zero)  result <= none_code();
    else if (finish_found) result <= found_code(pos);
  end

  // R2: a zero operand is answered on the next cycle with -1 and one cycle
  assert_zero_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && operand == '0) |=>
      (done && !busy && result == '1 && cycles == CYC_W'(1)));

  // R4: a found position costs position plus two cycles
  assert_latency_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !result[RES_W-1]) |-> (cycles == CYC_W'(result) + CYC_W'(2)));

  // R8: outputs hold between done pulses
  assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || ($stable(result) && $stable(cycles))));

  // R5: accepting a non-zero operand raises busy on the next cycle
  assert_busy_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && operand != '0) |=> (busy && !done));

  // R9: starting in a done cycle is taken
  assert_back_to_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start && operand != '0) |=> busy);

endmodule

// File: tb/msb_locator_test.sv
module msb_locator_test;

  localparam int WIDTH = 32;
  localparam int RES_W = 6;
  localparam int CYC_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [WIDTH-1:0] operand = '0;
  logic             busy, done;
  logic [RES_W-1:0] result;
  logic [CYC_W-1:0] cycles;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  msb_locator #(.WIDTH(WIDTH)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
    .busy(busy), .done(done), .result(result), .cycles(cycles)
  );

  // reference: scan from the top bit downward, -1 when nothing is set
  function automatic int ref_pos(input logic [WIDTH-1:0] v);
    for (int k = 0; k < WIDTH; k++)
      if (v[WIDTH-1-k]) return k;
    return -1;
  endfunction

  function automatic int ref_latency(input int p);
    return (p < 0) ? 1 : p + 2;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive start at the current falling edge, release at the next one
  task automatic launch(input logic [WIDTH-1:0] v);
    start   = 1'b1;
    operand = v;
    @(negedge clk);
    start   = 1'b0;
    operand = $urandom;
  endtask

  // called one falling edge after the accepting edge; returns at the done edge
  task automatic await_done(input logic [WIDTH-1:0] v);
    int p = ref_pos(v);
    int lat = 1;
    int exp_res = (p < 0) ? (1 << RES_W) - 1 : p;
    while (!done && lat < 200) begin
      check("R5", "busy while searching", int'(busy), 1);
      @(negedge clk);
      lat++;
    end
    check("R4", "latency", lat, ref_latency(p));
    check(p < 0 ? "R2" : "R3", "result", int'(result), exp_res);
    check("R8", "cycles", int'(cycles), ref_latency(p));
    check("R5", "busy low at done", int'(busy), 0);
  endtask

  task automatic run_one(input logic [WIDTH-1:0] v);
    launch(v);
    await_done(v);
    @(negedge clk);
    check("R6", "done single pulse", int'(done), 0);
  endtask

  initial begin
    logic [RES_W-1:0] held_r;
    logic [CYC_W-1:0] held_c;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", "busy at reset", int'(busy), 0);
    check("R1", "done at reset", int'(done), 0);
    check("R1", "result at reset", int'(result), 0);
    check("R1", "cycles at reset", int'(cycles), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    run_one('0);                        // R2
    run_one(32'h0000_0001);             // R3: 31
    run_one(32'h8000_0000);             // R3: 0
    run_one(32'hFFFF_FFFF);             // R3: 0
    run_one(32'h0001_0000);             // R3: 15
    run_one(32'h4000_0001);             // R3: 1

    // R8: outputs hold while idle
    held_r = result;
    held_c = cycles;
    repeat (5) @(negedge clk);
    check("R8", "result held", int'(result), int'(held_r));
    check("R8", "cycles held", int'(cycles), int'(held_c));

    // R7: start during busy is ignored
    launch(32'h0000_0800);              // position 20
    start = 1'b1; operand = 32'h8000_0000;
    @(negedge clk);
    start = 1'b0;
    begin
      int lat = 2;
      while (!done && lat < 200) begin @(negedge clk); lat++; end
      check("R7", "latency after ignored start", lat, 22);
      check("R7", "result after ignored start", int'(result), 20);
    end
    repeat (6) begin
      @(negedge clk);
      check("R7", "no extra done", int'(done), 0);
    end

    // R9: back to back, including zero after non-zero
    launch(32'h0000_0004);
    await_done(32'h0000_0004);
    launch('0);
    await_done('0);
    launch(32'h0200_0000);
    check("R9", "busy after back-to-back start", int'(busy), 1);
    await_done(32'h0200_0000);
    @(negedge clk);

    // random operands, spread over all positions
    for (int n = 0; n < 300; n++) begin
      logic [WIDTH-1:0] v = $urandom;
      v = v >> ($urandom % (WIDTH + 1));
      if ($urandom % 10 == 0) v = '0;
      run_one(v);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule